// File: doc/BRIEF.md
# Dual-Bus LCD Column Driver Command Interface

This block sits between a host processor bus and the control logic of a RAM-based LCD column driver. A strap input selects one of two 8-bit bus styles. The first uses separate active-low read and write strobes. The second uses an active-high enable pulse with a read/write level. The asynchronous strobes are brought into the core clock and edge-detected, so each bus cycle becomes exactly one internal event.

Writes with the address line low are opcodes. Writes with it high are parameter bytes or display data, and their meaning depends on the last opcode. Single-byte opcodes change display flags. Parameter opcodes route the next data byte into a configuration register. A two-step column-address load pushes a 10-bit address to the column counter. A memory-write mode turns every following data byte into a RAM write strobe. Reads return a status byte, or the output-port value once after a readback opcode. The data bus is modelled as a data-out value plus an output enable.

Top module: `lcd_cmd_if`

## Requirements
- R1: With `busSel`=0, one event is taken per rising edge of `wrRw` (active-low write). It is an opcode when `a0`=0 and a data byte when `a0`=1. A status read is driven while `rdEn` (active-low read) is low with `a0`=0.
- R2: With `busSel`=1, a transfer is taken when the `rdEn` enable pulse ends. `wrRw`=0 means write and `wrRw`=1 means read. `dataOe` is high while the enable is high with `wrRw`=1.
- R3: While `csN` is high, `dataOe` stays low and strobes have no effect on any register.
- R4: The status byte has these bits. Bit7 = `ramBusy`. Bit6 = page direction normal. Bit5 = column counting up. Bit4 = page scan. Bit3 = display off. Bit2 = sleep on. Bit1 = normal (non-inverted) display. Bit0 = 0. The following opcodes set the fields: 0xAF/0xAE display on/off; 0xA6/0xA7 normal/inverse; 0x95/0x94 sleep on/off; 0x5A/0x5B column up/down; 0x6A/0x6B page normal/inverted; 0x4A/0x4B page/column scan.
- R5: After reset the status byte is 0x7A, `frCode`=0x0A, `patCode`=0 and `portOut`=0.
- R6: Each of the opcodes 0xA8 (`dutyCode`), 0xCA (`frCode`), 0xCC (`patCode`), 0xC6 (`portOut`, low 5 bits), 0xB4 (`chipEnCode`), 0xBF (`clkDiv`) and 0x75 (`pageAddr`, low 5 bits) stores the next data byte. Opcode 0x75 also gives a one-cycle `pageLoad` pulse.
- R7: After opcode 0x15, the first data byte gives address bits [4:0] and the second gives bits [9:5]. The second byte loads `colAddr` and gives one `colLoad` pulse.
- R8: An opcode arriving between the two halves of a 0x15 load abandons it. `colAddr` stays unchanged and no `colLoad` occurs.
- R9: After 0x5C, each data byte gives one `ramWrStb` pulse with `ramWrData` equal to the byte. Any opcode ends this mode.
- R10: After 0xB6, the next read returns `portOut` in bits [4:0] with zeros above. Later reads return status.
- R11: Data bytes with no pending opcode, and the no-operation opcodes 0x25 and 0x44, change no output.
- R12: The busy bit follows `ramBusy` live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus style strap: 0 separate strobes, 1 enable plus read/write |
| csN | input | 1 | Active-low chip select |
| a0 | input | 1 | 0 opcode/status, 1 parameter/data |
| rdEn | input | 1 | Read strobe (active low) or enable (active high) |
| wrRw | input | 1 | Write strobe (active low) or read/write level |
| dataIn | input | 8 | Bus write data |
| ramBusy | input | 1 | RAM arbitration busy, reported in status |
| dataOut | output | 8 | Bus read data |
| dataOe | output | 1 | Bus drive enable |
| dispOn | output | 1 | Display enabled |
| invertOn | output | 1 | Inverse display |
| sleepOn | output | 1 | Sleep requested |
| colDec | output | 1 | Column counter counts down |
| pageNormal | output | 1 | Page direction normal |
| scanPage | output | 1 | Auto-advance along pages |
| dutyCode | output | 8 | Duty setting |
| frCode | output | 8 | FR interval setting |
| patCode | output | 8 | Drive pattern setting |
| chipEnCode | output | 8 | Per-chip display enable setting |
| clkDiv | output | 8 | Clock divide setting |
| portOut | output | 5 | General-purpose output pins |
| pageAddr | output | 5 | Page address to load |
| pageLoad | output | 1 | Page counter load pulse |
| colAddr | output | 10 | Column address to load |
| colLoad | output | 1 | Column counter load pulse |
| ramWrData | output | 8 | Display data byte |
| ramWrStb | output | 1 | Display data write pulse |

## Verification
A parameter-tracking state left stale would send the next data byte to the wrong register. It could also produce a spurious `colLoad` or `ramWrStb` pulse. Either shows on the outputs a few cycles after the following bus write. Flag corruption appears in the next status read. A lost readback-pending flag shows as a status byte where the port value was expected. The interrupted column load and the end of memory-write mode are both probed with a trailing data byte. Any leftover state is therefore exposed at once.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  localparam logic [7:0] OP_DISP_ON   = 8'hAF;
  localparam logic [7:0] OP_DISP_OFF  = 8'hAE;
  localparam logic [7:0] OP_NORMAL    = 8'hA6;
  localparam logic [7:0] OP_INVERSE   = 8'hA7;
  localparam logic [7:0] OP_SLEEP_ON  = 8'h95;
  localparam logic [7:0] OP_SLEEP_OFF = 8'h94;
  localparam logic [7:0] OP_COL_INC   = 8'h5A;
  localparam logic [7:0] OP_COL_DEC   = 8'h5B;
  localparam logic [7:0] OP_PAGE_NORM = 8'h6A;
  localparam logic [7:0] OP_PAGE_INV  = 8'h6B;
  localparam logic [7:0] OP_SCAN_PAGE = 8'h4A;
  localparam logic [7:0] OP_SCAN_COL  = 8'h4B;
  localparam logic [7:0] OP_MEM_WRITE = 8'h5C;
  localparam logic [7:0] OP_COL_SET   = 8'h15;
  localparam logic [7:0] OP_PORT_RB   = 8'hB6;
  localparam logic [7:0] OP_DUTY      = 8'hA8;
  localparam logic [7:0] OP_FR        = 8'hCA;
  localparam logic [7:0] OP_PATTERN   = 8'hCC;
  localparam logic [7:0] OP_PORT      = 8'hC6;
  localparam logic [7:0] OP_CHIP_EN   = 8'hB4;
  localparam logic [7:0] OP_PAGE      = 8'h75;
  localparam logic [7:0] OP_CLK_DIV   = 8'hBF;

  typedef enum logic [2:0] {
    PS_NONE, PS_DUTY, PS_FR, PS_PAT, PS_PORT, PS_CHIPEN, PS_PAGE, PS_CLKDIV
  } paramSel_e;

  typedef enum logic [3:0] {
    FO_NONE, FO_DISP_ON, FO_DISP_OFF, FO_NORMAL, FO_INVERSE, FO_SLEEP_ON,
    FO_SLEEP_OFF, FO_COL_INC, FO_COL_DEC, FO_PAGE_NORM, FO_PAGE_INV,
    FO_SCAN_PAGE, FO_SCAN_COL
  } flagOp_e;

  typedef struct packed {
    logic       cmdWr;
    logic       datWr;
    logic       rdDone;
    logic [7:0] byteVal;
  } busEv_t;

  typedef struct packed {
    flagOp_e    flagOp;
    logic       paramWr;
    paramSel_e  paramSel;
    logic       colLoWr;
    logic       colHiWr;
    logic       ramWr;
    logic       readbackSel;
    logic [7:0] byteVal;
  } ctlStb_t;

endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync
  import lcd_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              csN,
  input  logic              a0,
  input  logic              rdEn,
  input  logic              wrRw,
  input  logic [DATA_W-1:0] dataIn,
  output busEv_t            ev
);
  localparam int PW = DATA_W + 4;
  localparam int CW = $clog2(SYNC_STAGES + 2);
  localparam logic [CW-1:0] PRIME_END = CW'(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0][PW-1:0] pipe;
  logic [PW-1:0] cur;
  logic prevRd, prevWr;
  logic [CW-1:0] primeCnt;
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '1;
    else       pipe[0] <= {csN, a0, rdEn, wrRw, dataIn};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '1;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign cur = pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd   <= 1'b1;
      prevWr   <= 1'b1;
      primeCnt <= '0;
    end else begin
      prevRd <= cur[DATA_W+1];
      prevWr <= cur[DATA_W];
      if (!primed) primeCnt <= primeCnt + 1'b1;
    end
  end

  assign primed = (primeCnt == PRIME_END);

  logic selOk, curA0, curRd, curWr, wrEnd, rdEnd, eFall;
  assign selOk = primed && !cur[DATA_W+3];
  assign curA0 = cur[DATA_W+2];
  assign curRd = cur[DATA_W+1];
  assign curWr = cur[DATA_W];
  assign eFall = prevRd && !curRd;

  always_comb begin
    if (busSel) begin
      wrEnd = eFall && !curWr;
      rdEnd = eFall && curWr;
    end else begin
      wrEnd = !prevWr && curWr;
      rdEnd = !prevRd && curRd;
    end
    ev.cmdWr   = selOk && wrEnd && !curA0;
    ev.datWr   = selOk && wrEnd && curA0;
    ev.rdDone  = selOk && rdEnd;
    ev.byteVal = cur[DATA_W-1:0];
  end
endmodule

// File: rtl/lcd_cmd_ctrl.sv
module lcd_cmd_ctrl
  import lcd_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEv_t  ev,
  output ctlStb_t stb
);
  typedef enum logic [2:0] {ST_IDLE, ST_PARAM, ST_COL_LO, ST_COL_HI, ST_MEMWR} st_e;

  st_e       state, stateNxt;
  paramSel_e pendSel, pendSelNxt;
  logic      rbPend, rbPendNxt;

  always_comb begin
    stateNxt    = state;
    pendSelNxt  = pendSel;
    rbPendNxt   = rbPend;
    stb         = '0;
    stb.byteVal = ev.byteVal;
    if (ev.rdDone) rbPendNxt = 1'b0;
    if (ev.cmdWr) begin
      stateNxt   = ST_IDLE;
      pendSelNxt = PS_NONE;
      case (ev.byteVal)
        OP_DISP_ON:   stb.flagOp = FO_DISP_ON;
        OP_DISP_OFF:  stb.flagOp = FO_DISP_OFF;
        OP_NORMAL:    stb.flagOp = FO_NORMAL;
        OP_INVERSE:   stb.flagOp = FO_INVERSE;
        OP_SLEEP_ON:  stb.flagOp = FO_SLEEP_ON;
        OP_SLEEP_OFF: stb.flagOp = FO_SLEEP_OFF;
        OP_COL_INC:   stb.flagOp = FO_COL_INC;
        OP_COL_DEC:   stb.flagOp = FO_COL_DEC;
        OP_PAGE_NORM: stb.flagOp = FO_PAGE_NORM;
        OP_PAGE_INV:  stb.flagOp = FO_PAGE_INV;
        OP_SCAN_PAGE: stb.flagOp = FO_SCAN_PAGE;
        OP_SCAN_COL:  stb.flagOp = FO_SCAN_COL;
        OP_MEM_WRITE: stateNxt = ST_MEMWR;
        OP_COL_SET:   stateNxt = ST_COL_LO;
        OP_PORT_RB:   rbPendNxt = 1'b1;
        OP_DUTY:      begin stateNxt = ST_PARAM; pendSelNxt = PS_DUTY;   end
        OP_FR:        begin stateNxt = ST_PARAM; pendSelNxt = PS_FR;     end
        OP_PATTERN:   begin stateNxt = ST_PARAM; pendSelNxt = PS_PAT;    end
        OP_PORT:      begin stateNxt = ST_PARAM; pendSelNxt = PS_PORT;   end
        OP_CHIP_EN:   begin stateNxt = ST_PARAM; pendSelNxt = PS_CHIPEN; end
        OP_PAGE:      begin stateNxt = ST_PARAM; pendSelNxt = PS_PAGE;   end
        OP_CLK_DIV:   begin stateNxt = ST_PARAM; pendSelNxt = PS_CLKDIV; end
        default:      ;
      endcase
    end else if (ev.datWr) begin
      case (state)
        ST_PARAM: begin
          stb.paramWr  = 1'b1;
          stb.paramSel = pendSel;
          stateNxt     = ST_IDLE;
          pendSelNxt   = PS_NONE;
        end
        ST_COL_LO: begin stb.colLoWr = 1'b1; stateNxt = ST_COL_HI; end
        ST_COL_HI: begin stb.colHiWr = 1'b1; stateNxt = ST_IDLE;   end
        ST_MEMWR:  stb.ramWr = 1'b1;
        default:   ;
      endcase
    end
    stb.readbackSel = rbPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendSel <= PS_NONE;
      rbPend  <= 1'b0;
    end else begin
      state   <= stateNxt;
      pendSel <= pendSelNxt;
      rbPend  <= rbPendNxt;
    end
  end
endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_cmd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COL_HALF_W = 5,
  parameter int PAGE_W     = 5,
  parameter int PORT_W     = 5,
  parameter logic [DATA_W-1:0] FR_RESET = 8'h0A
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStb_t                 stb,
  input  logic                    ramBusy,
  output logic [DATA_W-1:0]       dataOut,
  output logic                    dispOn,
  output logic                    invertOn,
  output logic                    sleepOn,
  output logic                    colDec,
  output logic                    pageNormal,
  output logic                    scanPage,
  output logic [DATA_W-1:0]       dutyCode,
  output logic [DATA_W-1:0]       frCode,
  output logic [DATA_W-1:0]       patCode,
  output logic [DATA_W-1:0]       chipEnCode,
  output logic [DATA_W-1:0]       clkDiv,
  output logic [PORT_W-1:0]       portOut,
  output logic [PAGE_W-1:0]       pageAddr,
  output logic                    pageLoad,
  output logic [2*COL_HALF_W-1:0] colAddr,
  output logic                    colLoad,
  output logic [DATA_W-1:0]       ramWrData,
  output logic                    ramWrStb
);
  logic [COL_HALF_W-1:0] colLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispOn <= 1'b0; invertOn <= 1'b0; sleepOn <= 1'b0;
      colDec <= 1'b0; pageNormal <= 1'b1; scanPage <= 1'b1;
    end else begin
      case (stb.flagOp)
        FO_DISP_ON:   dispOn     <= 1'b1;
        FO_DISP_OFF:  dispOn     <= 1'b0;
        FO_NORMAL:    invertOn   <= 1'b0;
        FO_INVERSE:   invertOn   <= 1'b1;
        FO_SLEEP_ON:  sleepOn    <= 1'b1;
        FO_SLEEP_OFF: sleepOn    <= 1'b0;
        FO_COL_INC:   colDec     <= 1'b0;
        FO_COL_DEC:   colDec     <= 1'b1;
        FO_PAGE_NORM: pageNormal <= 1'b1;
        FO_PAGE_INV:  pageNormal <= 1'b0;
        FO_SCAN_PAGE: scanPage   <= 1'b1;
        FO_SCAN_COL:  scanPage   <= 1'b0;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyCode <= '0; frCode <= FR_RESET; patCode <= '0;
      chipEnCode <= '0; clkDiv <= '0; portOut <= '0;
      pageAddr <= '0; pageLoad <= 1'b0;
    end else begin
      pageLoad <= 1'b0;
      if (stb.paramWr) begin
        case (stb.paramSel)
          PS_DUTY:   dutyCode   <= stb.byteVal;
          PS_FR:     frCode     <= stb.byteVal;
          PS_PAT:    patCode    <= stb.byteVal;
          PS_CHIPEN: chipEnCode <= stb.byteVal;
          PS_CLKDIV: clkDiv     <= stb.byteVal;
          PS_PORT:   portOut    <= stb.byteVal[PORT_W-1:0];
          PS_PAGE: begin
            pageAddr <= stb.byteVal[PAGE_W-1:0];
            pageLoad <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colLo <= '0; colAddr <= '0; colLoad <= 1'b0;
      ramWrData <= '0; ramWrStb <= 1'b0;
    end else begin
      colLoad  <= 1'b0;
      ramWrStb <= 1'b0;
      if (stb.colLoWr) colLo <= stb.byteVal[COL_HALF_W-1:0];
      if (stb.colHiWr) begin
        colAddr <= {stb.byteVal[COL_HALF_W-1:0], colLo};
        colLoad <= 1'b1;
      end
      if (stb.ramWr) begin
        ramWrData <= stb.byteVal;
        ramWrStb  <= 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] statusByte;
  assign statusByte = {ramBusy, pageNormal, !colDec, scanPage, !dispOn,
                       sleepOn, !invertOn, 1'b0};
  assign dataOut = stb.readbackSel ? DATA_W'(portOut) : statusByte;
endmodule

// File: rtl/lcd_cmd_if.sv
module lcd_cmd_if
  import lcd_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int COL_HALF_W  = 5,
  parameter int PAGE_W      = 5,
  parameter int PORT_W      = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    csN,
  input  logic                    a0,
  input  logic                    rdEn,
  input  logic                    wrRw,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic                    ramBusy,
  output logic [DATA_W-1:0]       dataOut,
  output logic                    dataOe,
  output logic                    dispOn,
  output logic                    invertOn,
  output logic                    sleepOn,
  output logic                    colDec,
  output logic                    pageNormal,
  output logic                    scanPage,
  output logic [DATA_W-1:0]       dutyCode,
  output logic [DATA_W-1:0]       frCode,
  output logic [DATA_W-1:0]       patCode,
  output logic [DATA_W-1:0]       chipEnCode,
  output logic [DATA_W-1:0]       clkDiv,
  output logic [PORT_W-1:0]       portOut,
  output logic [PAGE_W-1:0]       pageAddr,
  output logic                    pageLoad,
  output logic [2*COL_HALF_W-1:0] colAddr,
  output logic                    colLoad,
  output logic [DATA_W-1:0]       ramWrData,
  output logic                    ramWrStb
);
  busEv_t  ev;
  ctlStb_t stb;

  assign dataOe = !csN && (busSel ? (rdEn && wrRw) : !rdEn);

  lcd_bus_sync #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rstN(rstN), .busSel(busSel), .csN(csN), .a0(a0),
    .rdEn(rdEn), .wrRw(wrRw), .dataIn(dataIn), .ev(ev)
  );

  lcd_cmd_ctrl u_ctrl (.clk(clk), .rstN(rstN), .ev(ev), .stb(stb));

  lcd_cmd_regs #(
    .DATA_W(DATA_W), .COL_HALF_W(COL_HALF_W), .PAGE_W(PAGE_W), .PORT_W(PORT_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .ramBusy(ramBusy), .dataOut(dataOut),
    .dispOn(dispOn), .invertOn(invertOn), .sleepOn(sleepOn), .colDec(colDec),
    .pageNormal(pageNormal), .scanPage(scanPage), .dutyCode(dutyCode),
    .frCode(frCode), .patCode(patCode), .chipEnCode(chipEnCode), .clkDiv(clkDiv),
    .portOut(portOut), .pageAddr(pageAddr), .pageLoad(pageLoad),
    .colAddr(colAddr), .colLoad(colLoad), .ramWrData(ramWrData),
    .ramWrStb(ramWrStb)
  );
endmodule

// File: rtl/lcd_cmd_if_chk.sv
module lcd_cmd_if_chk #(
  parameter int PAGE_W = 5,
  parameter int COL_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              dataOe,
  input logic [PAGE_W-1:0] pageAddr,
  input logic              pageLoad,
  input logic [COL_W-1:0]  colAddr,
  input logic              colLoad,
  input logic              ramWrStb
);
  // R3
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOe);

  // R6
  page_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pageAddr) |-> pageLoad);

  // R7
  col_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(colAddr) |-> colLoad);

  // R9
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrStb |-> (!colLoad && !pageLoad));

  // R7
  col_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |=> !colLoad);
endmodule

bind lcd_cmd_if lcd_cmd_if_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe), .pageAddr(pageAddr),
  .pageLoad(pageLoad), .colAddr(colAddr), .colLoad(colLoad), .ramWrStb(ramWrStb)
);

// File: tb/lcd_cmd_if_tb.sv
module lcd_cmd_if_tb;
  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, csN = 1'b1, a0 = 1'b0;
  logic rdEn = 1'b1, wrRw = 1'b1, ramBusy = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, dutyCode, frCode, patCode, chipEnCode, clkDiv, ramWrData;
  logic dataOe, dispOn, invertOn, sleepOn, colDec, pageNormal, scanPage;
  logic [4:0] portOut, pageAddr;
  logic [9:0] colAddr;
  logic pageLoad, colLoad, ramWrStb;

  int nVec = 0, nBad = 0;
  int ramCnt = 0, colCnt = 0, pageCnt = 0;

  always #5 clk = ~clk;

  lcd_cmd_if u_dut (.*);

  always @(negedge clk) begin
    if (ramWrStb) ramCnt++;
    if (colLoad)  colCnt++;
    if (pageLoad) pageCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr80(input logic isData, input logic [7:0] b, input logic cs = 1'b0);
    a0 = isData; dataIn = b; csN = cs; cyc(2);
    wrRw = 1'b0; cyc(3); wrRw = 1'b1; cyc(5);
    csN = 1'b1; cyc(3);
  endtask

  task automatic rd80(output logic [7:0] v, output logic oe, input logic cs = 1'b0);
    a0 = 1'b0; csN = cs; cyc(2);
    rdEn = 1'b0; cyc(3); v = dataOut; oe = dataOe;
    rdEn = 1'b1; cyc(5); csN = 1'b1; cyc(3);
  endtask

  task automatic wr68(input logic isData, input logic [7:0] b);
    a0 = isData; dataIn = b; wrRw = 1'b0; csN = 1'b0; cyc(2);
    rdEn = 1'b1; cyc(3); rdEn = 1'b0; cyc(5);
    csN = 1'b1; wrRw = 1'b1; cyc(3);
  endtask

  task automatic rd68(output logic [7:0] v, output logic oe);
    a0 = 1'b0; wrRw = 1'b1; csN = 1'b0; cyc(2);
    rdEn = 1'b1; cyc(3); v = dataOut; oe = dataOe;
    rdEn = 1'b0; cyc(5); csN = 1'b1; cyc(3);
  endtask

  // {a0, byte, expected status after it}
  localparam logic [16:0] VEC [14] = '{
    {1'b0, 8'hAF, 8'h72}, {1'b0, 8'hA7, 8'h70}, {1'b0, 8'h95, 8'h74},
    {1'b0, 8'h94, 8'h70}, {1'b0, 8'h5B, 8'h50}, {1'b0, 8'h6B, 8'h10},
    {1'b0, 8'h4B, 8'h00}, {1'b0, 8'hAE, 8'h08}, {1'b0, 8'hA6, 8'h0A},
    {1'b0, 8'h5A, 8'h2A}, {1'b0, 8'h6A, 8'h6A}, {1'b0, 8'h4A, 8'h7A},
    {1'b1, 8'h55, 8'h7A}, {1'b0, 8'h25, 8'h7A}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    cyc(3); rstN = 1'b1; cyc(6);

    // R5 reset state
    chk("R5 frCode", frCode, 8'h0A);
    chk("R5 patCode", patCode, 0);
    chk("R5 portOut", portOut, 0);
    chk("R3 idle dataOe", dataOe, 0);
    rd80(v, oe);
    chk("R5 status", v, 8'h7A);
    chk("R1 read dataOe", oe, 1);

    // R1 R4 R11 vector walk
    for (int i = 0; i < 14; i++) begin
      wr80(VEC[i][16], VEC[i][15:8]);
      rd80(v, oe);
      chk($sformatf("R4 vec%0d status", i), v, VEC[i][7:0]);
    end

    // R6 parameter opcodes
    wr80(0, 8'hCA); wr80(1, 8'h05); chk("R6 frCode", frCode, 8'h05);
    wr80(0, 8'hA8); wr80(1, 8'hF0); chk("R6 dutyCode", dutyCode, 8'hF0);
    wr80(0, 8'hCC); wr80(1, 8'h02); chk("R6 patCode", patCode, 8'h02);
    wr80(0, 8'hBF); wr80(1, 8'h33); chk("R6 clkDiv", clkDiv, 8'h33);
    wr80(0, 8'hB4); wr80(1, 8'h01); chk("R6 chipEnCode", chipEnCode, 8'h01);
    wr80(0, 8'h75); wr80(1, 8'hF3);
    chk("R6 pageAddr", pageAddr, 5'h13);
    chk("R6 pageLoad count", pageCnt, 1);
    wr80(1, 8'h77); chk("R11 stray data frCode", frCode, 8'h05);

    // R7 column set
    wr80(0, 8'h15); wr80(1, 8'h1F);
    chk("R7 no load after low half", colCnt, 0);
    wr80(1, 8'h13);
    chk("R7 colAddr", colAddr, 10'h27F);
    chk("R7 colLoad count", colCnt, 1);

    // R8 interrupted column set
    wr80(0, 8'h15); wr80(1, 8'h05); wr80(0, 8'h25); wr80(1, 8'h01);
    chk("R8 colAddr kept", colAddr, 10'h27F);
    chk("R8 colLoad count", colCnt, 1);

    // R9 memory write mode
    wr80(0, 8'h5C); wr80(1, 8'h11); wr80(1, 8'h22); wr80(1, 8'h33);
    chk("R9 ram strobes", ramCnt, 3);
    chk("R9 ram data", ramWrData, 8'h33);
    wr80(0, 8'h44); wr80(1, 8'h66);
    chk("R9 mode ended", ramCnt, 3);
    chk("R11 nop data", ramWrData, 8'h33);

    // R10 port readback
    wr80(0, 8'hC6); wr80(1, 8'hF5);
    chk("R10 portOut", portOut, 5'h15);
    wr80(0, 8'hB6);
    rd80(v, oe); chk("R10 readback", v, 8'h15);
    rd80(v, oe); chk("R10 status after", v, 8'h7A);

    // R3 chip select inactive
    wr80(0, 8'hAF, 1'b1);
    chk("R3 write ignored", dispOn, 0);
    rd80(v, oe, 1'b1);
    chk("R3 no drive", oe, 0);

    // R12 busy bit
    ramBusy = 1'b1;
    rd80(v, oe); chk("R12 busy status", v, 8'hFA);
    ramBusy = 1'b0;

    // R2 enable-style bus
    busSel = 1'b1; rdEn = 1'b0; wrRw = 1'b1; cyc(6);
    wr68(0, 8'hAF);
    chk("R2 display on", dispOn, 1);
    rd68(v, oe);
    chk("R2 status", v, 8'h72);
    chk("R2 dataOe", oe, 1);
    wr68(0, 8'hCA); wr68(1, 8'h09);
    chk("R2 param", frCode, 8'h09);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule